// File: doc/BRIEF.md
# Dual Auxiliary Address Generator

This block produces two memory addresses in every clock cycle for a load/store datapath. It holds a small register file of eight pointer registers, two index registers and one block-length register. Each of its two lanes picks a pointer register and an addressing mode, and forms an effective address from that register's current value. The lane also computes the modified pointer. The modifier is a step of displacement, an index step, a step that wraps inside a circular buffer, or a bit-reversed (reverse-carry) step. Both lanes can write their modified pointers back to the shared file at the same clock edge.

A separate load port initialises any register of the file. Decoding, memory and pipeline hazards are outside the block. Lane outputs are combinational from the registered file, and the file changes only at the clock edge. In any cycle, both lanes therefore see the values the registers held before that edge.

Register selects on the load port are: 0 to 7 for the pointer registers, 8 for index register A, 9 for index register B and 10 for the block length. Lane mode codes are: 0 displacement, 1 index A, 2 index B, 3 circular with displacement step, 4 circular with index A step, 5 bit-reversed with index A step, 6 and 7 reserved.

Top module: `dual_agu`

## Requirements
- R1: After reset, all eight pointer registers, both index registers and the block-length register read as zero.
- R2: When `ld_en` is high, `ld_data` is written at the clock edge into the register chosen by `ld_sel` (0–7 pointer, 8 index A, 9 index B, 10 block length). Select values 11–15 change no register.
- R3: With `lane_pre` low, a lane's `lane_addr` equals the selected pointer's current value. With `lane_pre` high, it equals the modified value. `lane_next` always carries the modified value.
- R4: Mode 0 steps the pointer by the 8-bit `lane_disp` taken as an unsigned magnitude. `lane_sub` high subtracts and low adds, modulo 2^32.
- R5: Mode 1 steps by index A and mode 2 by index B, with the same add/subtract choice as R4.
- R6: Modes 3 (step = displacement) and 4 (step = index A) are circular. L is the block length. The buffer starts at the pointer with its low k bits cleared, where 2^k is the smallest power of two not below L, and it covers L words. A stepped result at or above start+L has L subtracted. A result below start has L added. With L = 0 the step is linear. Correct wrapping requires a step no larger than L.
- R7: Mode 5 adds index A to the pointer with carries moving from the most significant bit toward the least significant bit across all 32 bits. `lane_sub` is ignored in this mode.
- R8: Modes 6 and 7 leave the modified value equal to the current pointer.
- R9: A lane writes `lane_next` into its pointer register at the clock edge only when both `lane_vld` and `lane_upd` are high. Otherwise that register is untouched.
- R10: If both lanes write the same pointer register in one cycle, lane 1's value is kept. A lane write overrides a load-port write to the same register in that cycle.
- R11: Both lanes operate in the same cycle on different registers, each reading the pre-edge contents. A lane reading a register that the other lane updates in that cycle sees the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_en | input | 1 | Load-port write enable |
| ld_sel | input | 4 | Load-port register select |
| ld_data | input | 32 | Load-port data |
| lane_vld | input | 2 | Per-lane request valid |
| lane_ar | input | 2x3 | Per-lane pointer register select |
| lane_mode | input | 2x3 | Per-lane addressing mode code |
| lane_pre | input | 2 | Per-lane pre-modify select (1) vs post-modify (0) |
| lane_sub | input | 2 | Per-lane subtract (1) vs add (0) |
| lane_upd | input | 2 | Per-lane write-back enable |
| lane_disp | input | 2x8 | Per-lane displacement magnitude |
| lane_addr | output | 2x32 | Per-lane effective address |
| lane_next | output | 2x32 | Per-lane modified pointer value |

## Verification
The hardest states to reach from the ports are the circular wrap at both ends of a buffer whose start is not zero, and a full bit-reversed pass. Both need the pointer to walk through many consecutive write-backs. The stimulus sets a non-power-of-two block length, parks a pointer near the top of its aligned window and steps it repeatedly in both directions. It then runs a 16-step reverse-carry sweep with index A set to half the length, and compares every step with a reference model kept in the bench. Same-cycle collisions between the two lanes, and between a lane and the load port, are driven on purpose to expose the write priority.

// File: rtl/agu_pkg.sv
package agu_pkg;

    typedef enum logic [2:0] {
        AM_DISP      = 3'd0,
        AM_IDXA      = 3'd1,
        AM_IDXB      = 3'd2,
        AM_CIRC_DISP = 3'd3,
        AM_CIRC_IDXA = 3'd4,
        AM_BITREV    = 3'd5,
        AM_RSV6      = 3'd6,
        AM_RSV7      = 3'd7
    } am_e;

    localparam int unsigned LANES   = 2;
    localparam int unsigned LSEL_W  = 4;
    localparam int unsigned SEL_IXA = 8;
    localparam int unsigned SEL_IXB = 9;
    localparam int unsigned SEL_BLK = 10;

endpackage

// File: rtl/agu_regs.sv
module agu_regs
    import agu_pkg::*;
#(
    parameter int W   = 32,
    parameter int NAR = 8,
    parameter int SW  = 3
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           ld_en,
    input  logic [LSEL_W-1:0]              ld_sel,
    input  logic [W-1:0]                   ld_data,
    input  logic [LANES-1:0]               wr_en,
    input  logic [LANES-1:0][SW-1:0]       wr_sel,
    input  logic [LANES-1:0][W-1:0]        wr_data,
    output logic [NAR-1:0][W-1:0]          ar_q,
    output logic [W-1:0]                   ixa_q,
    output logic [W-1:0]                   ixb_q,
    output logic [W-1:0]                   blk_q
);

    // pointer file: load first, then lane 0, then lane 1 (last wins)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ar_q <= '0;
        end else begin
            for (int i = 0; i < NAR; i++) begin
                if (ld_en && ld_sel == LSEL_W'(i))
                    ar_q[i] <= ld_data;
                for (int l = 0; l < LANES; l++) begin
                    if (wr_en[l] && wr_sel[l] == SW'(i))
                        ar_q[i] <= wr_data[l];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ixa_q <= '0;
            ixb_q <= '0;
            blk_q <= '0;
        end else if (ld_en) begin
            if (ld_sel == LSEL_W'(SEL_IXA)) ixa_q <= ld_data;
            if (ld_sel == LSEL_W'(SEL_IXB)) ixb_q <= ld_data;
            if (ld_sel == LSEL_W'(SEL_BLK)) blk_q <= ld_data;
        end
    end

endmodule

// File: rtl/agu_lane.sv
module agu_lane
    import agu_pkg::*;
#(
    parameter int W  = 32,
    parameter int DW = 8
) (
    input  logic [W-1:0]  ar_val,
    input  logic [W-1:0]  ixa,
    input  logic [W-1:0]  ixb,
    input  logic [W-1:0]  blk,
    input  logic [2:0]    mode,
    input  logic          pre,
    input  logic          sub,
    input  logic [DW-1:0] disp,
    output logic [W-1:0]  addr,
    output logic [W-1:0]  next
);

    localparam int XW = W + 2;

    function automatic logic [W-1:0] flip(input logic [W-1:0] v);
        logic [W-1:0] r;
        for (int i = 0; i < W; i++) r[i] = v[W-1-i];
        return r;
    endfunction

    // fill every bit below the highest set bit
    function automatic logic [W-1:0] smear(input logic [W-1:0] v);
        logic [W-1:0] m;
        m = v;
        for (int s = 1; s < W; s = s * 2) m = m | (m >> s);
        return m;
    endfunction

    am_e                  md;
    logic [W-1:0]         step;
    logic [W-1:0]         lin_res;
    logic [W-1:0]         circ_res;
    logic [W-1:0]         brev_res;
    logic [W-1:0]         win_mask;
    logic [W-1:0]         win_start;
    logic signed [XW-1:0] raw;
    logic signed [XW-1:0] lo_x;
    logic signed [XW-1:0] hi_x;
    logic signed [XW-1:0] blk_x;

    always_comb begin
        md = am_e'(mode);
        case (md)
            AM_DISP, AM_CIRC_DISP:            step = W'(disp);
            AM_IDXA, AM_CIRC_IDXA, AM_BITREV: step = ixa;
            AM_IDXB:                          step = ixb;
            default:                          step = '0;
        endcase
    end

    assign lin_res = sub ? (ar_val - step) : (ar_val + step);

    always_comb begin
        win_mask  = smear(blk - W'(1));
        win_start = ar_val & ~win_mask;
        blk_x     = $signed({2'b00, blk});
        lo_x      = $signed({2'b00, win_start});
        hi_x      = lo_x + blk_x;
        raw       = sub ? ($signed({2'b00, ar_val}) - $signed({2'b00, step}))
                        : ($signed({2'b00, ar_val}) + $signed({2'b00, step}));
        if (blk == '0)
            circ_res = lin_res;
        else if (raw < lo_x)
            circ_res = W'(raw + blk_x);
        else if (raw >= hi_x)
            circ_res = W'(raw - blk_x);
        else
            circ_res = W'(raw);
    end

    assign brev_res = flip(flip(ar_val) + flip(ixa));

    always_comb begin
        case (md)
            AM_DISP, AM_IDXA, AM_IDXB:  next = lin_res;
            AM_CIRC_DISP, AM_CIRC_IDXA: next = circ_res;
            AM_BITREV:                  next = brev_res;
            default:                    next = ar_val;
        endcase
    end

    assign addr = pre ? next : ar_val;

endmodule

// File: rtl/dual_agu.sv
module dual_agu
    import agu_pkg::*;
#(
    parameter int W   = 32,
    parameter int NAR = 8,
    parameter int DW  = 8,
    localparam int SW = $clog2(NAR)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ld_en,
    input  logic [LSEL_W-1:0]        ld_sel,
    input  logic [W-1:0]             ld_data,
    input  logic [LANES-1:0]         lane_vld,
    input  logic [LANES-1:0][SW-1:0] lane_ar,
    input  logic [LANES-1:0][2:0]    lane_mode,
    input  logic [LANES-1:0]         lane_pre,
    input  logic [LANES-1:0]         lane_sub,
    input  logic [LANES-1:0]         lane_upd,
    input  logic [LANES-1:0][DW-1:0] lane_disp,
    output logic [LANES-1:0][W-1:0]  lane_addr,
    output logic [LANES-1:0][W-1:0]  lane_next
);

    logic [NAR-1:0][W-1:0]   ar_q;
    logic [W-1:0]            ixa_q;
    logic [W-1:0]            ixb_q;
    logic [W-1:0]            blk_q;
    logic [LANES-1:0]        wr_en;
    logic [LANES-1:0][W-1:0] ar_rd;

    agu_regs #(.W(W), .NAR(NAR), .SW(SW)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .ld_en   (ld_en),
        .ld_sel  (ld_sel),
        .ld_data (ld_data),
        .wr_en   (wr_en),
        .wr_sel  (lane_ar),
        .wr_data (lane_next),
        .ar_q    (ar_q),
        .ixa_q   (ixa_q),
        .ixb_q   (ixb_q),
        .blk_q   (blk_q)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign ar_rd[g] = ar_q[lane_ar[g]];
        assign wr_en[g] = lane_vld[g] & lane_upd[g];

        agu_lane #(.W(W), .DW(DW)) u_lane (
            .ar_val (ar_rd[g]),
            .ixa    (ixa_q),
            .ixb    (ixb_q),
            .blk    (blk_q),
            .mode   (lane_mode[g]),
            .pre    (lane_pre[g]),
            .sub    (lane_sub[g]),
            .disp   (lane_disp[g]),
            .addr   (lane_addr[g]),
            .next   (lane_next[g])
        );
    end

endmodule

// File: rtl/agu_chk.sv
module agu_chk
    import agu_pkg::*;
#(
    parameter int W   = 32,
    parameter int NAR = 8,
    parameter int DW  = 8,
    localparam int SW = $clog2(NAR)
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     ld_en,
    input logic [LANES-1:0]         lane_vld,
    input logic [LANES-1:0][SW-1:0] lane_ar,
    input logic [LANES-1:0][2:0]    lane_mode,
    input logic [LANES-1:0]         lane_pre,
    input logic [LANES-1:0]         lane_upd,
    input logic [LANES-1:0][DW-1:0] lane_disp,
    input logic [LANES-1:0][W-1:0]  lane_addr,
    input logic [LANES-1:0][W-1:0]  lane_next,
    input logic [NAR-1:0][W-1:0]    ar_q
);

    // R3
    post_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lane_vld[0] && !lane_pre[0] |-> lane_addr[0] == ar_q[lane_ar[0]]);

    // R3
    pre_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lane_vld[1] && lane_pre[1] |-> lane_addr[1] == lane_next[1]);

    // R8
    rsv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lane_vld[0] && lane_mode[0] >= 3'd6 |-> lane_next[0] == ar_q[lane_ar[0]]);

    // R10
    lane1_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lane_vld[1] && lane_upd[1] |=> ar_q[$past(lane_ar[1])] == $past(lane_next[1]));

    // R9
    lane0_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lane_vld[0] && lane_upd[0] &&
        !(lane_vld[1] && lane_upd[1] && lane_ar[1] == lane_ar[0])
        |=> ar_q[$past(lane_ar[0])] == $past(lane_next[0]));

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_en && !(lane_vld[0] && lane_upd[0]) && !(lane_vld[1] && lane_upd[1])
        |=> $stable(ar_q));

endmodule

bind dual_agu agu_chk #(.W(W), .NAR(NAR), .DW(DW)) i_agu_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ld_en     (ld_en),
    .lane_vld  (lane_vld),
    .lane_ar   (lane_ar),
    .lane_mode (lane_mode),
    .lane_pre  (lane_pre),
    .lane_upd  (lane_upd),
    .lane_disp (lane_disp),
    .lane_addr (lane_addr),
    .lane_next (lane_next),
    .ar_q      (ar_q)
);

// File: tb/test_dual_agu.sv
module test_dual_agu;

    localparam int CLK_PERIOD = 10;
    localparam int W          = 32;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             ld_en = 1'b0;
    logic [3:0]       ld_sel = '0;
    logic [W-1:0]     ld_data = '0;
    logic [1:0]       lane_vld = '0;
    logic [1:0][2:0]  lane_ar = '0;
    logic [1:0][2:0]  lane_mode = '0;
    logic [1:0]       lane_pre = '0;
    logic [1:0]       lane_sub = '0;
    logic [1:0]       lane_upd = '0;
    logic [1:0][7:0]  lane_disp = '0;
    logic [1:0][W-1:0] lane_addr;
    logic [1:0][W-1:0] lane_next;

    int n_chk = 0;
    int n_bad = 0;

    // reference state
    logic [W-1:0] m_ar [8];
    logic [W-1:0] m_ixa, m_ixb, m_blk;

    always #(CLK_PERIOD/2) clk = ~clk;

    dual_agu i_dual_agu (
        .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_sel(ld_sel), .ld_data(ld_data),
        .lane_vld(lane_vld), .lane_ar(lane_ar), .lane_mode(lane_mode),
        .lane_pre(lane_pre), .lane_sub(lane_sub), .lane_upd(lane_upd),
        .lane_disp(lane_disp), .lane_addr(lane_addr), .lane_next(lane_next)
    );

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [W-1:0] rc_add(input logic [W-1:0] a, input logic [W-1:0] b);
        logic [W-1:0] s;
        logic c;
        c = 1'b0;
        for (int i = W-1; i >= 0; i--) begin
            s[i] = a[i] ^ b[i] ^ c;
            c    = (a[i] & b[i]) | (c & (a[i] ^ b[i]));
        end
        return s;
    endfunction

    function automatic logic [W-1:0] ref_next(input logic [W-1:0] a, input logic [2:0] md,
                                              input logic sb, input logic [7:0] d);
        logic [W-1:0] st, lin;
        longint r, p, base, len;
        case (md)
            3'd0, 3'd3: st = {24'd0, d};
            3'd1, 3'd4: st = m_ixa;
            3'd2:       st = m_ixb;
            3'd5:       return rc_add(a, m_ixa);
            default:    return a;
        endcase
        lin = sb ? a - st : a + st;
        if (md <= 3'd2 || m_blk == '0) return lin;
        len = longint'(m_blk);
        p = 1;
        while (p < len) p = p * 2;
        base = longint'(a) - (longint'(a) % p);
        r = sb ? longint'(a) - longint'(st) : longint'(a) + longint'(st);
        if (r < base) r = r + len;
        else if (r >= base + len) r = r - len;
        return r[W-1:0];
    endfunction

    task automatic set_lane(input int l, input logic [2:0] ar, input logic [2:0] md,
                            input logic pre, input logic sb, input logic upd, input logic [7:0] d);
        lane_vld[l]  = 1'b1;
        lane_ar[l]   = ar;
        lane_mode[l] = md;
        lane_pre[l]  = pre;
        lane_sub[l]  = sb;
        lane_upd[l]  = upd;
        lane_disp[l] = d;
    endtask

    task automatic apply_load_model();
        if (ld_en) begin
            if (ld_sel < 4'd8) m_ar[ld_sel[2:0]] = ld_data;
            else if (ld_sel == 4'd8)  m_ixa = ld_data;
            else if (ld_sel == 4'd9)  m_ixb = ld_data;
            else if (ld_sel == 4'd10) m_blk = ld_data;
        end
    endtask

    // called just after a falling edge with lanes/load already driven
    task automatic issue(input string tag);
        logic [W-1:0] nx [2];
        logic [W-1:0] ad [2];
        #1;
        for (int l = 0; l < 2; l++) begin
            nx[l] = ref_next(m_ar[lane_ar[l]], lane_mode[l], lane_sub[l], lane_disp[l]);
            ad[l] = lane_pre[l] ? nx[l] : m_ar[lane_ar[l]];
            if (lane_vld[l]) begin
                check({tag, " next"}, lane_next[l], nx[l]);
                check({tag, " addr"}, lane_addr[l], ad[l]);
            end
        end
        @(posedge clk);
        apply_load_model();
        for (int l = 0; l < 2; l++)
            if (lane_vld[l] && lane_upd[l]) m_ar[lane_ar[l]] = nx[l];
        @(negedge clk);
        lane_vld = '0;
        lane_upd = '0;
        ld_en    = 1'b0;
    endtask

    task automatic load(input logic [3:0] sel, input logic [W-1:0] d);
        ld_en = 1'b1; ld_sel = sel; ld_data = d;
        @(posedge clk);
        apply_load_model();
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    task automatic read_ar(input int r, input string tag);
        set_lane(0, 3'(r), 3'd0, 1'b0, 1'b0, 1'b0, 8'd0);
        #1;
        check(tag, lane_addr[0], m_ar[r]);
        lane_vld = '0;
    endtask

    task automatic t_reset();
        for (int r = 0; r < 8; r++) begin
            read_ar(r, "R1 pointer reset");
            check("R1 pointer reset abs", lane_addr[0], '0);
        end
        set_lane(0, 3'd0, 3'd1, 1'b1, 1'b0, 1'b0, 8'd0);
        issue("R1 index A reset");
        set_lane(1, 3'd0, 3'd3, 1'b1, 1'b0, 1'b0, 8'd5);
        #1 check("R6 zero length linear", lane_next[1], 32'd5);
        issue("R6 zero length");
    endtask

    task automatic t_load();
        for (int r = 0; r < 8; r++) load(4'(r), 32'h1000_0000 + 32'(r) * 32'h111);
        load(4'd8, 32'h0000_0040);
        load(4'd9, 32'h0000_0300);
        for (int r = 0; r < 8; r++) read_ar(r, "R2 load pointer");
        load(4'd15, 32'hDEAD_BEEF);
        load(4'd11, 32'hCAFE_F00D);
        for (int r = 0; r < 8; r++) read_ar(r, "R2 unused select ignored");
        set_lane(0, 3'd0, 3'd1, 1'b1, 1'b0, 1'b0, 8'd0);
        issue("R2 index A loaded");
        set_lane(0, 3'd0, 3'd2, 1'b1, 1'b0, 1'b0, 8'd0);
        issue("R2 index B loaded");
    endtask

    task automatic t_disp();
        set_lane(0, 3'd1, 3'd0, 1'b0, 1'b0, 1'b1, 8'h10);
        issue("R4 post add");
        read_ar(1, "R3 R4 post add writeback");
        set_lane(1, 3'd2, 3'd0, 1'b1, 1'b1, 1'b1, 8'hFF);
        issue("R4 pre sub");
        read_ar(2, "R3 R4 pre sub writeback");
        load(4'd0, 32'h0000_0004);
        set_lane(0, 3'd0, 3'd0, 1'b1, 1'b1, 1'b1, 8'd9);
        #1 check("R4 wrap below zero", lane_next[0], 32'hFFFF_FFFB);
        issue("R4 wrap");
    endtask

    task automatic t_index();
        set_lane(0, 3'd3, 3'd1, 1'b1, 1'b0, 1'b1, 8'd0);
        issue("R5 index A pre add");
        set_lane(1, 3'd4, 3'd2, 1'b0, 1'b1, 1'b1, 8'd0);
        issue("R5 index B post sub");
        read_ar(3, "R5 index A writeback");
        read_ar(4, "R5 index B writeback");
    endtask

    task automatic t_circ();
        load(4'd10, 32'd6);
        load(4'd5, 32'h0000_0103);
        for (int k = 0; k < 5; k++) begin
            set_lane(0, 3'd5, 3'd3, 1'b0, 1'b0, 1'b1, 8'd2);
            issue("R6 circular up");
        end
        read_ar(5, "R6 after top wrap");
        for (int k = 0; k < 5; k++) begin
            set_lane(1, 3'd5, 3'd3, 1'b1, 1'b1, 1'b1, 8'd3);
            issue("R6 circular down");
        end
        read_ar(5, "R6 after bottom wrap");
        load(4'd5, 32'h0000_0105);
        set_lane(0, 3'd5, 3'd3, 1'b0, 1'b0, 1'b1, 8'd1);
        #1 check("R6 top end", lane_next[0], 32'h0000_0100);
        issue("R6 top end");
        set_lane(0, 3'd5, 3'd3, 1'b0, 1'b1, 1'b1, 8'd1);
        #1 check("R6 bottom end", lane_next[0], 32'h0000_0105);
        issue("R6 bottom end");
        load(4'd8, 32'd4);
        for (int k = 0; k < 4; k++) begin
            set_lane(0, 3'd5, 3'd4, 1'b0, 1'b0, 1'b1, 8'd0);
            issue("R6 circular index step");
        end
    endtask

    task automatic t_bitrev();
        logic [3:0] seq [16] = '{0, 8, 4, 12, 2, 10, 6, 14, 1, 9, 5, 13, 3, 11, 7, 15};
        load(4'd8, 32'd8);
        load(4'd6, 32'd0);
        for (int k = 0; k < 16; k++) begin
            set_lane(0, 3'd6, 3'd5, 1'b0, k[0], 1'b1, 8'd0);
            #1 check("R7 fft16 order", lane_addr[0], {28'd0, seq[k]});
            issue("R7 bit reversed");
        end
        read_ar(6, "R7 sequence end");
    endtask

    task automatic t_reserved();
        set_lane(0, 3'd7, 3'd6, 1'b1, 1'b0, 1'b1, 8'h33);
        issue("R8 code 6");
        set_lane(1, 3'd7, 3'd7, 1'b1, 1'b1, 1'b1, 8'h44);
        issue("R8 code 7");
        read_ar(7, "R8 reserved keeps pointer");
    endtask

    task automatic t_noupd();
        set_lane(0, 3'd1, 3'd0, 1'b1, 1'b0, 1'b0, 8'h55);
        issue("R9 no update");
        read_ar(1, "R9 upd low untouched");
        set_lane(1, 3'd1, 3'd0, 1'b1, 1'b0, 1'b1, 8'h55);
        lane_vld[1] = 1'b0;
        issue("R9 invalid lane");
        read_ar(1, "R9 vld low untouched");
    endtask

    task automatic t_conflict();
        set_lane(0, 3'd2, 3'd0, 1'b0, 1'b0, 1'b1, 8'h01);
        set_lane(1, 3'd2, 3'd0, 1'b0, 1'b0, 1'b1, 8'h80);
        issue("R10 both lanes same reg");
        read_ar(2, "R10 lane 1 wins");
        ld_en = 1'b1; ld_sel = 4'd3; ld_data = 32'h7777_0000;
        set_lane(0, 3'd3, 3'd0, 1'b0, 1'b0, 1'b1, 8'h02);
        issue("R10 lane vs load");
        read_ar(3, "R10 lane beats load");
    endtask

    task automatic t_parallel();
        set_lane(0, 3'd4, 3'd0, 1'b0, 1'b0, 1'b1, 8'h20);
        set_lane(1, 3'd4, 3'd6, 1'b0, 1'b0, 1'b0, 8'h00);
        #1 check("R11 other lane sees old", lane_addr[1], m_ar[4]);
        issue("R11 read while written");
        set_lane(0, 3'd0, 3'd0, 1'b1, 1'b0, 1'b1, 8'h0A);
        set_lane(1, 3'd1, 3'd2, 1'b0, 1'b1, 1'b1, 8'h00);
        issue("R11 two registers");
        read_ar(0, "R11 lane 0 register");
        read_ar(1, "R11 lane 1 register");
        read_ar(4, "R11 earlier write");
    endtask

    initial begin
        for (int r = 0; r < 8; r++) m_ar[r] = '0;
        m_ixa = '0; m_ixb = '0; m_blk = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_load();
        t_disp();
        t_index();
        t_circ();
        t_bitrev();
        t_reserved();
        t_noupd();
        t_conflict();
        t_parallel();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule